// File: doc/BRIEF.md
# Vectored Interrupt Entry Sequencer

This block steers a small processor core into and out of interrupt handlers. Devices raise request lines, each wired to a fixed priority level. The block holds each request pending. When the core signals that its current instruction has retired, the block picks the highest eligible level and saves the interrupted context to a descending memory stack, one word per handshake. It then raises the core to privileged mode at the new level and runs an acknowledge handshake with the devices.

A device that answers supplies a vector number. If no device answers within a fixed window, the block uses a reserved vector derived from the level. The vector selects a word in a table in memory. That word is loaded into the core's program counter as the handler entry point. A return strobe from the core makes the block pop the saved words in reverse order. The popped words restore the general registers, the mode and the level, and then the program counter.

The core is assumed to stall and hold `pc_in` and `gpr_in` steady while `seq_busy` is high. A device is assumed to drop its request line once its level has been acknowledged.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset the block is in user mode (`sup_mode`=0) at level 0. It makes no memory request and no acknowledge cycle. `seq_busy`, `pc_load` and `gpr_wr` are 0. The stack pointer starts at SP_INIT (0x1000).
- R2: Request line i carries level i+1. A single-cycle pulse on a line is held pending. Entry begins only on a cycle where `insn_done` is 1, and a pending level is still serviced later if it could not be taken at once.
- R3: Entry writes four words, each at the stack pointer minus 4, and the pointer descends by 4 per accepted handshake. The words are, in this order: the PC, a status word, general register 0 and general register 1. The status word holds the interrupted mode in bit 8 and the interrupted level in bits 2:0.
- R4: After the last push, `sup_mode` is 1 and `cur_level` is the new level before `iack_valid` rises. `iack_level` shows that level during the acknowledge cycle.
- R5: When `iack_resp` is 1 during the acknowledge cycle, the block reads the table word at `table_base` + 4*`iack_vec`. One cycle after the read handshake, it pulses `pc_load` for one cycle with that word on `pc_out`.
- R6: If no response arrives, `iack_valid` stays high for exactly ACK_WAIT (4) cycles. The block then reads the table entry for vector 24 + level.
- R7: A response in the final cycle of the window takes precedence over the level-based fallback.
- R8: When several levels are pending, the highest wins. A level at or below `cur_level` causes no entry and stays pending until the level in service drops below it.
- R9: On `rti` while `cur_level` is nonzero, the block reads the four saved words upward from the stack pointer. It replays general register 1 and then register 0 through one-cycle `gpr_wr` pulses. The status word restores the mode and the level, and `pc_load` then delivers the saved PC.
- R10: `rti` while `cur_level` is 0 causes no memory access and changes neither the mode nor the level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_req | input | NLVL | Request lines, line i at level i+1 |
| insn_done | input | 1 | Current instruction has retired |
| rti | input | 1 | Return-from-interrupt strobe |
| pc_in | input | DW | Core PC to save |
| gpr_in | input | NGPR*DW | Core general registers to save |
| table_base | input | DW | Base address of the vector table |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | DW | Memory byte address |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid with mem_ready |
| mem_ready | input | 1 | Handshake complete |
| iack_valid | output | 1 | Acknowledge cycle active |
| iack_level | output | LW | Level being acknowledged |
| iack_resp | input | 1 | A device answers |
| iack_vec | input | VW | Vector number from the device |
| seq_busy | output | 1 | Sequence in progress, core stalls |
| pc_load | output | 1 | Load pc_out into the PC |
| pc_out | output | DW | New PC value |
| sup_mode | output | 1 | 1 = privileged mode |
| cur_level | output | LW | Level in service, 0 = none |
| gpr_wr | output | 1 | Restore one general register |
| gpr_wr_idx | output | GIW | Register index to restore |
| gpr_wr_data | output | DW | Restored register value |

## Verification
The bench makes a request that is pulsed while an instruction is still running. A design that acts on requests only at the retire edge would lose it. It makes a request at a masked level that must survive two returns before it is serviced. A design that drops such requests, or services them while masked, fails here.

It answers the acknowledge on the last cycle of the window. An off-by-one in the window would then fetch the level-based vector instead of the device's vector. It also checks the exact status word pushed by a nested entry, and the order in which the stack is popped. Swapped pop order or a stale mode bit would corrupt the state restored to the core.

// File: rtl/irq_entry_pkg.sv
// Shared types for the interrupt entry sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package irq_entry_pkg;

    // Sequencer phases
    typedef enum logic [2:0] {
        ST_IDLE,   // running user or handler code
        ST_PUSH,   // saving context words
        ST_ACK,    // acknowledge window open
        ST_VEC,    // fetching handler address
        ST_POP     // restoring context words
    } seq_state_t;

    // Bit of the saved status word holding the mode
    localparam int STAT_MODE_BIT = 8;

endpackage

// File: rtl/irq_prio_pick.sv
// Chooses the highest pending level above the level now in service.
// Assumes: bit i of pend stands for level i+1; level 0 means idle.
module irq_prio_pick #(
    parameter int NLVL = 7,
    parameter int LW   = 3
) (
    input  logic [NLVL-1:0] pend,
    input  logic [LW-1:0]   cur_level,
    output logic            win_valid,
    output logic [LW-1:0]   win_level
);

    // Later (higher) levels overwrite earlier ones, so the highest wins
    always_comb begin
        win_valid = 1'b0;
        win_level = '0;
        for (int i = 0; i < NLVL; i++) begin
            if (pend[i] && (LW'(i + 1) > cur_level)) begin
                win_valid = 1'b1;
                win_level = LW'(i + 1);
            end
        end
    end

endmodule

// File: rtl/irq_ack_timer.sv
// Counts the cycles of an open acknowledge window and flags its last cycle.
// Assumes: run stays high for the whole window and drops when it closes.
module irq_ack_timer #(
    parameter int ACK_WAIT = 4,
    parameter int TW       = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic last
);

    logic [TW-1:0] cnt_q;

    // Cycle counter, cleared whenever the window is closed
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Final cycle of the window
    assign last = run && (cnt_q == TW'(ACK_WAIT - 1));

    AST_WINDOW_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (run && cnt_q == TW'(ACK_WAIT - 1)) |=> !run); // R6

endmodule

// File: rtl/irq_entry_seq.sv
// Interrupt entry and return sequencer.
// Saves PC, status and general registers to a descending memory stack,
// enters privileged mode, runs an acknowledge window, fetches the handler
// address from a vector table and loads it into the core PC; reverses this
// on a return strobe.
// Assumes: the core stalls with pc_in/gpr_in steady while seq_busy is high;
// a device drops its request once its level has been acknowledged.
module irq_entry_seq #(
    parameter int              NLVL      = 7,
    parameter int              NGPR      = 2,
    parameter int              DW        = 32,
    parameter int              VW        = 8,
    parameter int              ACK_WAIT  = 4,
    parameter int              AUTO_BASE = 24,
    parameter logic [DW-1:0]   SP_INIT   = 'h1000,
    localparam int             LW        = $clog2(NLVL + 1),
    localparam int             GIW       = (NGPR > 1) ? $clog2(NGPR) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NLVL-1:0]      irq_req,
    input  logic                 insn_done,
    input  logic                 rti,
    input  logic [DW-1:0]        pc_in,
    input  logic [NGPR*DW-1:0]   gpr_in,
    input  logic [DW-1:0]        table_base,
    output logic                 mem_req,
    output logic                 mem_we,
    output logic [DW-1:0]        mem_addr,
    output logic [DW-1:0]        mem_wdata,
    input  logic [DW-1:0]        mem_rdata,
    input  logic                 mem_ready,
    output logic                 iack_valid,
    output logic [LW-1:0]        iack_level,
    input  logic                 iack_resp,
    input  logic [VW-1:0]        iack_vec,
    output logic                 seq_busy,
    output logic                 pc_load,
    output logic [DW-1:0]        pc_out,
    output logic                 sup_mode,
    output logic [LW-1:0]        cur_level,
    output logic                 gpr_wr,
    output logic [GIW-1:0]       gpr_wr_idx,
    output logic [DW-1:0]        gpr_wr_data
);
    import irq_entry_pkg::*;

    localparam int NWORDS = NGPR + 2;
    localparam int CW     = $clog2(NWORDS);
    localparam int TW     = (ACK_WAIT > 1) ? $clog2(ACK_WAIT) : 1;

    seq_state_t        state_q;
    logic [CW-1:0]     cnt_q;
    logic [DW-1:0]     sp_q;
    logic              sup_q;
    logic [LW-1:0]     lvl_q;
    logic [LW-1:0]     tgt_q;
    logic [VW-1:0]     vec_q;
    logic              pc_load_q;
    logic [DW-1:0]     pc_q;
    logic              gw_q;
    logic [GIW-1:0]    gw_idx_q;
    logic [DW-1:0]     gw_data_q;
    logic [NLVL-1:0]   pend_q;
    logic [NLVL-1:0]   clr_vec;
    logic              win_valid;
    logic [LW-1:0]     win_level;
    logic              ack_last;
    logic              ack_leave;
    logic [DW-1:0]     stat_w;
    logic [DW-1:0]     push_word;
    int                pop_k;

    // Pending requests plus this cycle's lines feed the priority pick
    irq_prio_pick #(.NLVL(NLVL), .LW(LW)) u_pick (
        .pend      (pend_q | irq_req),
        .cur_level (lvl_q),
        .win_valid (win_valid),
        .win_level (win_level)
    );

    // Acknowledge window timer
    irq_ack_timer #(.ACK_WAIT(ACK_WAIT), .TW(TW)) u_ack_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state_q == ST_ACK),
        .last  (ack_last)
    );

    assign ack_leave = (state_q == ST_ACK) && (iack_resp || ack_last);

    // Clear the pending bit of the level whose acknowledge just closed
    always_comb begin
        for (int i = 0; i < NLVL; i++) begin
            clr_vec[i] = ack_leave && (lvl_q == LW'(i + 1));
        end
    end

    // Pending request latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= (pend_q | irq_req) & ~clr_vec;
        end
    end

    // Status word of the context being saved
    always_comb begin
        stat_w                = '0;
        stat_w[STAT_MODE_BIT] = sup_q;
        stat_w[LW-1:0]        = lvl_q;
    end

    // Word to push for the current push index
    always_comb begin
        int gsel;
        gsel = int'(cnt_q) - 2;
        if (gsel < 0) gsel = 0;
        push_word = gpr_in[gsel*DW +: DW];
        if (cnt_q == CW'(0)) push_word = pc_in;
        else if (cnt_q == CW'(1)) push_word = stat_w;
    end

    // Position in the save order of the word being popped
    assign pop_k = NWORDS - 1 - int'(cnt_q);

    // Memory and acknowledge port drive
    always_comb begin
        mem_req  = (state_q == ST_PUSH) || (state_q == ST_VEC) || (state_q == ST_POP);
        mem_we   = (state_q == ST_PUSH);
        mem_addr = sp_q;
        if (state_q == ST_PUSH) mem_addr = sp_q - DW'(4);
        else if (state_q == ST_VEC) mem_addr = table_base + (DW'(vec_q) << 2);
        mem_wdata = push_word;
    end

    // Sequencer state, stack pointer, mode and level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            cnt_q     <= '0;
            sp_q      <= SP_INIT;
            sup_q     <= 1'b0;
            lvl_q     <= '0;
            tgt_q     <= '0;
            vec_q     <= '0;
            pc_load_q <= 1'b0;
            pc_q      <= '0;
            gw_q      <= 1'b0;
            gw_idx_q  <= '0;
            gw_data_q <= '0;
        end else begin
            pc_load_q <= 1'b0;
            gw_q      <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    cnt_q <= '0;
                    if (rti && lvl_q != '0) begin
                        state_q <= ST_POP;
                    end else if (insn_done && win_valid) begin
                        tgt_q   <= win_level;
                        state_q <= ST_PUSH;
                    end
                end
                ST_PUSH: begin
                    if (mem_ready) begin
                        sp_q <= sp_q - DW'(4);
                        if (cnt_q == CW'(NWORDS - 1)) begin
                            cnt_q   <= '0;
                            sup_q   <= 1'b1;
                            lvl_q   <= tgt_q;
                            state_q <= ST_ACK;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                ST_ACK: begin
                    if (iack_resp) begin
                        vec_q   <= iack_vec;
                        state_q <= ST_VEC;
                    end else if (ack_last) begin
                        vec_q   <= VW'(AUTO_BASE) + VW'(lvl_q);
                        state_q <= ST_VEC;
                    end
                end
                ST_VEC: begin
                    if (mem_ready) begin
                        pc_load_q <= 1'b1;
                        pc_q      <= mem_rdata;
                        state_q   <= ST_IDLE;
                    end
                end
                ST_POP: begin
                    if (mem_ready) begin
                        sp_q  <= sp_q + DW'(4);
                        cnt_q <= cnt_q + 1'b1;
                        if (pop_k >= 2) begin
                            gw_q      <= 1'b1;
                            gw_idx_q  <= GIW'(pop_k - 2);
                            gw_data_q <= mem_rdata;
                        end else if (pop_k == 1) begin
                            sup_q <= mem_rdata[STAT_MODE_BIT];
                            lvl_q <= mem_rdata[LW-1:0];
                        end else begin
                            pc_load_q <= 1'b1;
                            pc_q      <= mem_rdata;
                            state_q   <= ST_IDLE;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign iack_valid  = (state_q == ST_ACK);
    assign iack_level  = lvl_q;
    assign seq_busy    = (state_q != ST_IDLE);
    assign pc_load     = pc_load_q;
    assign pc_out      = pc_q;
    assign sup_mode    = sup_q;
    assign cur_level   = lvl_q;
    assign gpr_wr      = gw_q;
    assign gpr_wr_idx  = gw_idx_q;
    assign gpr_wr_data = gw_data_q;

    AST_ENTRY_AFTER_INSN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PUSH && $past(state_q) == ST_IDLE) |-> $past(insn_done)); // R2

    AST_PUSH_DESCENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_ready) |=> (sp_q == $past(sp_q) - DW'(4))); // R3

    AST_ACK_PRIVILEGED: assert property (@(posedge clk) disable iff (!rst_n)
        iack_valid |-> (sup_mode && cur_level != '0)); // R4

    AST_RESP_ENDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (iack_valid && iack_resp) |=> !iack_valid); // R5

    AST_PC_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |=> !pc_load); // R5

    AST_ENTRY_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> (win_level > cur_level)); // R8

    AST_RTI_LEVEL0: assert property (@(posedge clk) disable iff (!rst_n)
        (!seq_busy && rti && !insn_done && cur_level == '0) |=> !mem_req); // R10

endmodule

// File: tb/irq_entry_seq_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks queue the expected memory, PC and register
// events; a negedge monitor answers memory and acknowledge cycles and
// compares each observed event with the head of the queue.
module irq_entry_seq_tb_top;

    localparam int          NLVL      = 7;
    localparam int          NGPR      = 2;
    localparam int          DW        = 32;
    localparam int          VW        = 8;
    localparam int          ACK_WAIT  = 4;
    localparam int          AUTO_BASE = 24;
    localparam logic [31:0] SP0       = 32'h0000_1000;
    localparam logic [31:0] TBASE     = 32'h0000_8000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NLVL-1:0]   irq_req = '0;
    logic              insn_done = 1'b0;
    logic              rti = 1'b0;
    logic [DW-1:0]     pc_in = '0;
    logic [NGPR*DW-1:0] gpr_in = '0;
    logic              mem_req, mem_we;
    logic [DW-1:0]     mem_addr, mem_wdata;
    logic [DW-1:0]     mem_rdata = '0;
    logic              mem_ready = 1'b0;
    logic              iack_valid;
    logic [2:0]        iack_level;
    logic              iack_resp = 1'b0;
    logic [VW-1:0]     iack_vec = '0;
    logic              seq_busy, pc_load, sup_mode, gpr_wr;
    logic [DW-1:0]     pc_out, gpr_wr_data;
    logic [2:0]        cur_level;
    logic [0:0]        gpr_wr_idx;

    always #2.5 clk = ~clk;

    irq_entry_seq #(
        .NLVL(NLVL), .NGPR(NGPR), .DW(DW), .VW(VW),
        .ACK_WAIT(ACK_WAIT), .AUTO_BASE(AUTO_BASE), .SP_INIT(SP0)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .insn_done(insn_done),
        .rti(rti), .pc_in(pc_in), .gpr_in(gpr_in), .table_base(TBASE),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .iack_valid(iack_valid), .iack_level(iack_level), .iack_resp(iack_resp),
        .iack_vec(iack_vec), .seq_busy(seq_busy), .pc_load(pc_load),
        .pc_out(pc_out), .sup_mode(sup_mode), .cur_level(cur_level),
        .gpr_wr(gpr_wr), .gpr_wr_idx(gpr_wr_idx), .gpr_wr_data(gpr_wr_data)
    );

    typedef struct {
        int          kind;   // 0 write, 1 read, 2 PC load, 3 register restore
        logic [31:0] a;
        logic [31:0] b;
        string       rq;
    } ev_t;

    ev_t         exp_q[$];
    logic [31:0] mem [logic [31:0]];
    int          n_chk = 0;
    int          n_bad = 0;
    int          resp_delay = -1;
    int          ack_cyc = 0;
    int          ack_seen = 0;
    logic [2:0]  lvl_seen = '0;
    bit          done = 1'b0;

    logic [31:0] m_sp = SP0;
    logic        m_sup = 1'b0;
    logic [2:0]  m_lvl = '0;
    logic [31:0] c_pc[$], c_st[$], c_g0[$], c_g1[$];

    task automatic chk(string rq, logic [31:0] act, logic [31:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", rq, act, expv);
        end
    endtask

    task automatic observe(int kind, logic [31:0] a, logic [31:0] b);
        ev_t e;
        if (exp_q.size() == 0) begin
            n_chk++;
            n_bad++;
            $display("FAIL %s: actual event kind %0d at %h expected none",
                     (kind == 2) ? "R5" : (kind == 3) ? "R9" : "R3", kind, a);
        end else begin
            e = exp_q.pop_front();
            chk(e.rq, 32'(kind), 32'(e.kind));
            chk(e.rq, a, e.a);
            chk(e.rq, b, e.b);
        end
    endtask

    task automatic push_exp(int kind, logic [31:0] a, logic [31:0] b, string rq);
        ev_t e;
        e.kind = kind; e.a = a; e.b = b; e.rq = rq;
        exp_q.push_back(e);
    endtask

    // Monitor: answers memory and acknowledge, compares observed events
    always @(negedge clk) begin
        if (rst_n) begin
            if (pc_load) observe(2, pc_out, 32'h0);
            if (gpr_wr)  observe(3, 32'(gpr_wr_idx), gpr_wr_data);
            if (iack_valid) begin
                if (ack_cyc == 0) lvl_seen = iack_level;
                ack_seen++;
                iack_resp = (ack_cyc == resp_delay);
                ack_cyc++;
            end else begin
                ack_cyc   = 0;
                iack_resp = 1'b0;
            end
            if (mem_ready) begin
                mem_ready = 1'b0;
            end else if (mem_req) begin
                mem_ready = 1'b1;
                if (mem_we) begin
                    mem[mem_addr] = mem_wdata;
                    observe(0, mem_addr, mem_wdata);
                end else begin
                    mem_rdata = mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
                    observe(1, mem_addr, 32'h0);
                end
            end
        end
    end

    task automatic wait_idle(string rq);
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (exp_q.size() == 0 && !seq_busy && !pc_load && !gpr_wr) break;
        end
        chk(rq, 32'(exp_q.size()), 32'h0);
        exp_q.delete();
    endtask

    // Count cycles with a memory request over n cycles; expect none
    task automatic quiet(int n, string rq);
        int hits = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (mem_req || iack_valid) hits++;
        end
        chk(rq, 32'(hits), 32'h0);
    endtask

    task automatic pulse_req(logic [NLVL-1:0] mask, logic with_done);
        @(negedge clk);
        irq_req = mask; insn_done = with_done;
        @(negedge clk);
        irq_req = '0; insn_done = 1'b0;
    endtask

    // Driver: queue expected entry events, then trigger the entry
    task automatic enter(logic [NLVL-1:0] mask, int lvl, int rdly,
                         logic [7:0] rvec, string rq);
        logic [31:0] st, pcv, g0, g1, vec;
        st = '0; st[8] = m_sup; st[2:0] = m_lvl;
        pcv = 32'h0000_4000 + 32'(lvl * 16);
        g0  = 32'h1111_0000 + 32'(lvl);
        g1  = 32'h2222_0000 + 32'(lvl);
        vec = (rdly < 0) ? 32'(AUTO_BASE + lvl) : 32'(rvec);
        push_exp(0, m_sp - 4,  pcv, "R3");
        push_exp(0, m_sp - 8,  st,  "R3");
        push_exp(0, m_sp - 12, g0,  "R3");
        push_exp(0, m_sp - 16, g1,  "R3");
        push_exp(1, TBASE + 4 * vec, 32'h0, rq);
        push_exp(2, 32'hA000_0000 + vec, 32'h0, rq);
        m_sp = m_sp - 16;
        c_pc.push_back(pcv); c_st.push_back(st);
        c_g0.push_back(g0);  c_g1.push_back(g1);
        pc_in = pcv; gpr_in = {g1, g0};
        resp_delay = rdly; iack_vec = rvec; ack_seen = 0;
        pulse_req(mask, 1'b1);
        wait_idle(rq);
        m_sup = 1'b1; m_lvl = 3'(lvl);
        chk("R4", 32'(sup_mode), 32'h1);
        chk("R4", 32'(cur_level), 32'(lvl));
        chk("R4", 32'(lvl_seen), 32'(lvl));
        chk((rdly < 0) ? "R6" : "R7", 32'(ack_seen),
            (rdly < 0) ? 32'(ACK_WAIT) : 32'(rdly + 1));
    endtask

    // Driver: queue expected return events, then strobe rti
    task automatic leave(string rq);
        logic [31:0] st, pcv, g0, g1;
        pcv = c_pc.pop_back(); st = c_st.pop_back();
        g0 = c_g0.pop_back();  g1 = c_g1.pop_back();
        push_exp(1, m_sp,      32'h0, rq);
        push_exp(3, 32'h1,     g1,    rq);
        push_exp(1, m_sp + 4,  32'h0, rq);
        push_exp(3, 32'h0,     g0,    rq);
        push_exp(1, m_sp + 8,  32'h0, rq);
        push_exp(1, m_sp + 12, 32'h0, rq);
        push_exp(2, pcv,       32'h0, rq);
        m_sp = m_sp + 16;
        @(negedge clk); rti = 1'b1;
        @(negedge clk); rti = 1'b0;
        wait_idle(rq);
        m_sup = st[8]; m_lvl = st[2:0];
        chk(rq, 32'(sup_mode), 32'(m_sup));
        chk(rq, 32'(cur_level), 32'(m_lvl));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    // Watchdog
    initial begin
        #(5.0 * 100000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    // Main sequence
    initial begin
        for (int v = 0; v < 256; v++) mem[TBASE + 32'(4 * v)] = 32'hA000_0000 + 32'(v);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", 32'(sup_mode), 32'h0);
        chk("R1", 32'(cur_level), 32'h0);
        chk("R1", 32'(mem_req), 32'h0);
        chk("R1", 32'(iack_valid), 32'h0);
        chk("R1", 32'(seq_busy), 32'h0);
        chk("R1", 32'(pc_load | gpr_wr), 32'h0);

        // R2 pulse at level 3 mid-instruction: held, no entry yet
        pulse_req(7'b0000100, 1'b0);
        quiet(6, "R2");
        // R5 entry with device vector 0x40, answered at once
        enter('0, 3, 0, 8'h40, "R5");
        // R6 nested level 5, no device answers: vector 29
        enter(7'b0010000, 5, -1, 8'h00, "R6");
        // R8 level 2 is masked under level 5
        pulse_req(7'b0000010, 1'b1);
        quiet(8, "R8");
        chk("R8", 32'(cur_level), 32'h5);
        // R9 unwind both levels
        leave("R9");
        leave("R9");
        chk("R9", 32'(m_sp), SP0);
        // R2 the masked level 2 is still pending; R7 answer on last window cycle
        enter('0, 2, ACK_WAIT - 1, 8'h11, "R7");
        leave("R9");
        // R8 levels 6 and 7 together: 7 wins
        enter(7'b1100000, 7, 1, 8'h22, "R8");
        leave("R9");
        // R10 rti at level 0 does nothing
        @(negedge clk); rti = 1'b1;
        @(negedge clk); rti = 1'b0;
        quiet(6, "R10");
        chk("R10", 32'(sup_mode), 32'h0);
        chk("R10", 32'(cur_level), 32'h0);
        // R8 level 6 waited behind 7 and is serviced now, fallback vector 30
        enter('0, 6, -1, 8'h00, "R8");
        leave("R9");
        finish_run();
    end

endmodule